// File: doc/BRIEF.md
# Split Transaction Response Timeout and Retry Timer

This block times an outstanding asynchronous transaction while it waits for its response. Software programs a timeout limit in mixed units: a whole number of seconds plus a number of 1/8000-second units. The block counts the 8 kHz cycle tick to measure that limit. A typical fraction setting is 800 (0x320), which gives 100 ms. The same block also counts single-phase transmit retries against a separate 4-bit retry limit.

A start pulse opens a wait window. From then on, the fraction counter advances on every tick. It rolls over after 7999 and carries into the seconds counter. When the elapsed time reaches the programmed limit, the block gives a one-clock timeout pulse and drops busy. A stop pulse, given when the response arrives, closes the window without a timeout. Matching responses to requests and the retransmission itself belong to neighbouring logic.

Top module: `resp_wait_timer`

## Requirements
- R1: After reset, `busy`, `timeoutPulse` and `retriesExhausted` are all low.
- R2: A start pulse clears the elapsed time, the retry count and `retriesExhausted`, and `busy` is high from the next cycle. This holds even when busy was already high, and a start overrides a stop, tick or retry in the same cycle.
- R3: With limit S seconds and F fractions, `timeoutPulse` rises in the cycle after the clock edge that samples the (S*8000+F)-th tick since start, and `busy` falls in that same cycle. Cycles without a tick do not count, and ticks while idle are ignored.
- R4: The 13-bit fraction count runs 0 to 7999 and then wraps to 0, adding one to the 3-bit seconds count. A limit of 1 s plus 3 fractions therefore expires after 8003 ticks.
- R5: `timeoutPulse` is high for exactly one clock cycle.
- R6: A stop pulse without start clears `busy` and never produces `timeoutPulse`. This includes a stop that arrives in the same cycle as the tick that would have expired the limit.
- R7: A limit of 0 seconds and 0 fractions expires on the first tick.
- R8: A fraction limit above 7999 is treated as 7999.
- R9: `retriesExhausted` rises in the cycle after the retry pulse whose running count, since start, exceeds the 4-bit retry limit. It then stays high until the next start. With a limit of 0, the first retry sets it; with a limit of 2, the third does.
- R10: Retry pulses while not busy are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleTick | input | 1 | One-clock strobe at 8 kHz |
| startPulse | input | 1 | Opens a new wait window |
| stopPulse | input | 1 | Response received, closes the window |
| retryPulse | input | 1 | One single-phase retry attempt |
| limitSec | input | 3 | Timeout seconds |
| limitFrac | input | 13 | Timeout fractions in 1/8000 s |
| retryLimit | input | 4 | Maximum retries allowed |
| timeoutPulse | output | 1 | One-clock timeout strobe |
| retriesExhausted | output | 1 | Retry count exceeded the limit |
| busy | output | 1 | Wait window open |

## Verification
The timeout path is tried with several limit pairs:
- Fraction-only limits of 1, 5 and 800, which pin down the exact tick count.
- A zero limit, which separates "expire on first tick" from a hang.
- A full second, and one second plus three fractions, which expose a wrong rollover point or a missing carry.
- An out-of-range fraction, which shows whether clamping happens.

Ticks are sent back to back and also spaced by idle cycles, which tells tick counting apart from cycle counting. Directed cases cover:
- a restart while busy;
- a stop before expiry and a stop on the expiring tick;
- retry limits of 0 and 2;
- a start that clears the exhausted flag;
- retries while idle.

// File: rtl/resp_wait_pkg.sv
package resp_wait_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;    // restart elapsed time and retry count
    logic advance;     // count one tick
    logic countRetry;  // count one retry attempt
  } dpCtl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } waitState_t;
endpackage

// File: rtl/resp_wait_dp.sv
module resp_wait_dp
  import resp_wait_pkg::*;
#(
  parameter int FRAC_W = 13,
  parameter int SEC_W = 3,
  parameter int RETRY_W = 4,
  parameter int TICKS_PER_SEC = 8000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [SEC_W-1:0]   limitSec,
  input  logic [FRAC_W-1:0]  limitFrac,
  input  logic [RETRY_W-1:0] retryLimit,
  output logic               limitHit,
  output logic               retryOver
);
  localparam int RCNT_W = RETRY_W + 1;
  localparam logic [FRAC_W-1:0] FRAC_MAX = FRAC_W'(TICKS_PER_SEC - 1);

  logic [FRAC_W-1:0] fracCnt, nextFrac, effFrac;
  logic [SEC_W-1:0]  secCnt, nextSec;
  logic [RCNT_W-1:0] retryCnt;
  logic              fracWrap, limitZero;

  always_comb begin
    fracWrap  = (fracCnt == FRAC_MAX);
    nextFrac  = fracWrap ? '0 : fracCnt + 1'b1;
    nextSec   = fracWrap ? secCnt + 1'b1 : secCnt;
    effFrac   = (limitFrac > FRAC_MAX) ? FRAC_MAX : limitFrac;
    limitZero = (limitSec == '0) && (effFrac == '0);
    limitHit  = limitZero || ((nextFrac == effFrac) && (nextSec == limitSec));
    retryOver = (retryCnt > {1'b0, retryLimit});
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      fracCnt <= '0;
      secCnt  <= '0;
    end else if (ctl.advance) begin
      fracCnt <= nextFrac;
      secCnt  <= nextSec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      retryCnt <= '0;
    end else if (ctl.countRetry && (retryCnt != '1)) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  // R4: fraction count stays within one second
  assert_frac_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    fracCnt <= FRAC_MAX);

  // R4: rollover restarts the fraction count and moves the seconds count
  assert_carry_on_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.clearAll && fracCnt == FRAC_MAX)
      |=> (fracCnt == '0) && (secCnt != $past(secCnt)));

  // R9: the retry count never falls except on restart
  assert_retry_monotonic_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clearAll |=> retryCnt >= $past(retryCnt));
endmodule

// File: rtl/resp_wait_ctrl.sv
module resp_wait_ctrl
  import resp_wait_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cycleTick,
  input  logic   startPulse,
  input  logic   stopPulse,
  input  logic   retryPulse,
  input  logic   limitHit,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   timeoutPulse
);
  waitState_t state;

  assign busy = (state == ST_WAIT);

  always_comb begin
    ctl.clearAll   = startPulse;
    ctl.advance    = busy && cycleTick && !startPulse && !stopPulse;
    ctl.countRetry = busy && retryPulse && !startPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= 1'b0;
      if (startPulse) begin
        state <= ST_WAIT;
      end else if (stopPulse) begin
        state <= ST_IDLE;
      end else if (ctl.advance && limitHit) begin
        state        <= ST_IDLE;
        timeoutPulse <= 1'b1;
      end
    end
  end

  // R5: timeout strobe lasts one cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  // R3: busy is low while the timeout strobe is high
  assert_idle_on_timeout_R3: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> !busy);

  // R3: no timeout can come out of an idle cycle
  assert_idle_no_timeout_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> !timeoutPulse);

  // R6: a stop closes the window quietly
  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && !startPulse) |=> (!busy && !timeoutPulse));

  // R2: a start always opens the window
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (busy && !timeoutPulse));
endmodule

// File: rtl/resp_wait_timer.sv
module resp_wait_timer
  import resp_wait_pkg::*;
#(
  parameter int FRAC_W = 13,
  parameter int SEC_W = 3,
  parameter int RETRY_W = 4,
  parameter int TICKS_PER_SEC = 8000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleTick,
  input  logic               startPulse,
  input  logic               stopPulse,
  input  logic               retryPulse,
  input  logic [SEC_W-1:0]   limitSec,
  input  logic [FRAC_W-1:0]  limitFrac,
  input  logic [RETRY_W-1:0] retryLimit,
  output logic               timeoutPulse,
  output logic               retriesExhausted,
  output logic               busy
);
  dpCtl_t ctl;
  logic   limitHit;

  resp_wait_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cycleTick    (cycleTick),
    .startPulse   (startPulse),
    .stopPulse    (stopPulse),
    .retryPulse   (retryPulse),
    .limitHit     (limitHit),
    .ctl          (ctl),
    .busy         (busy),
    .timeoutPulse (timeoutPulse)
  );

  resp_wait_dp #(
    .FRAC_W        (FRAC_W),
    .SEC_W         (SEC_W),
    .RETRY_W       (RETRY_W),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .limitSec   (limitSec),
    .limitFrac  (limitFrac),
    .retryLimit (retryLimit),
    .limitHit   (limitHit),
    .retryOver  (retriesExhausted)
  );

  // R1: flags are quiet in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!busy && !timeoutPulse && !retriesExhausted));
endmodule

// File: tb/test_resp_wait_timer.sv
module test_resp_wait_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleTick = 1'b0;
  logic        startPulse = 1'b0;
  logic        stopPulse = 1'b0;
  logic        retryPulse = 1'b0;
  logic [2:0]  limitSec = '0;
  logic [12:0] limitFrac = '0;
  logic [3:0]  retryLimit = '0;
  logic        timeoutPulse, retriesExhausted, busy;

  int total = 0;
  int failed = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  resp_wait_timer i_resp_wait_timer (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .startPulse(startPulse),
    .stopPulse(stopPulse), .retryPulse(retryPulse), .limitSec(limitSec),
    .limitFrac(limitFrac), .retryLimit(retryLimit), .timeoutPulse(timeoutPulse),
    .retriesExhausted(retriesExhausted), .busy(busy)
  );

  // Vectors: seconds, fractions, idle cycles between ticks, expected ticks
  localparam int NV = 7;
  localparam int V_SEC[NV]  = '{0, 0, 0,   0, 1,    1,    0};
  localparam int V_FRAC[NV] = '{1, 5, 800, 0, 0,    3,    8191};
  localparam int V_GAP[NV]  = '{0, 1, 0,   0, 0,    2,    0};
  localparam int V_EXP[NV]  = '{1, 5, 800, 1, 8000, 8003, 7999};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startWin(input int s, input int f);
    @(negedge clk);
    limitSec = 3'(s);
    limitFrac = 13'(f);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // Counts ticks until the timeout strobe; -1 if none within limit
  task automatic countToTimeout(input int gap, output int ticks, output bit earlyIdle);
    ticks = 0;
    earlyIdle = 0;
    for (int cyc = 0; cyc < 40000; cyc++) begin
      cycleTick = ((cyc % (gap + 1)) == 0);
      @(negedge clk);
      if (cycleTick) ticks++;
      cycleTick = 1'b0;
      if (timeoutPulse) return;
      if (!busy) earlyIdle = 1;
    end
    ticks = -1;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      cycleTick = 1'b1;
      @(negedge clk);
    end
    cycleTick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failed++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    if (!summaryDone) $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int t;
    bit early;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !timeoutPulse && !retriesExhausted, "R1 reset flags",
          {busy, timeoutPulse, retriesExhausted}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector walk: R3 exact count, R4 carry, R7 zero limit, R8 clamp
    for (int v = 0; v < NV; v++) begin
      startWin(V_SEC[v], V_FRAC[v]);
      check(busy, "R2 busy after start", busy, 1);
      countToTimeout(V_GAP[v], t, early);
      check(t == V_EXP[v], "R3/R4/R7/R8 ticks to timeout", t, V_EXP[v]);
      check(!early && !busy, "R3 busy until timeout then low", busy, 0);
      @(negedge clk);
      check(!timeoutPulse, "R5 timeout pulse single cycle", timeoutPulse, 0);
    end

    // R3 ticks while idle are ignored
    tickN(20);
    check(!timeoutPulse && !busy, "R3 idle ticks ignored", {busy, timeoutPulse}, 0);

    // R2 restart while busy begins a fresh count
    startWin(0, 5);
    tickN(3);
    cycleTick = 1'b1;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cycleTick = 1'b0;
    countToTimeout(0, t, early);
    check(t == 5, "R2 restart resets elapsed time", t, 5);

    // R6 stop before expiry
    startWin(0, 10);
    tickN(3);
    stopPulse = 1'b1;
    cycleTick = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
    cycleTick = 1'b0;
    check(!busy && !timeoutPulse, "R6 stop clears busy", {busy, timeoutPulse}, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      cycleTick = 1'b1;
      @(negedge clk);
      if (timeoutPulse) seen = 1;
    end
    cycleTick = 1'b0;
    check(!seen, "R6 no timeout after stop", seen, 0);

    // R6 stop on the expiring tick
    startWin(0, 4);
    tickN(3);
    stopPulse = 1'b1;
    cycleTick = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
    cycleTick = 1'b0;
    check(!timeoutPulse && !busy, "R6 stop wins over final tick", timeoutPulse, 0);
    @(negedge clk);
    check(!timeoutPulse, "R6 no late timeout", timeoutPulse, 0);

    // R9 retry limit 0
    retryLimit = 4'd0;
    startWin(0, 1000);
    retryPulse = 1'b1;
    @(negedge clk);
    retryPulse = 1'b0;
    check(retriesExhausted, "R9 limit 0 first retry exhausts", retriesExhausted, 1);
    @(negedge clk);
    check(retriesExhausted, "R9 exhausted is sticky", retriesExhausted, 1);

    // R2 start clears the exhausted flag
    startWin(0, 1000);
    check(!retriesExhausted, "R2 start clears exhausted", retriesExhausted, 0);

    // R9 retry limit 2
    retryLimit = 4'd2;
    for (int i = 0; i < 2; i++) begin
      retryPulse = 1'b1;
      @(negedge clk);
      retryPulse = 1'b0;
      @(negedge clk);
    end
    check(!retriesExhausted, "R9 limit 2 two retries allowed", retriesExhausted, 0);
    retryPulse = 1'b1;
    @(negedge clk);
    retryPulse = 1'b0;
    check(retriesExhausted, "R9 limit 2 third retry exhausts", retriesExhausted, 1);

    // R10 retries while idle are not counted
    startWin(0, 1000);
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
    retryLimit = 4'd0;
    for (int i = 0; i < 3; i++) begin
      retryPulse = 1'b1;
      @(negedge clk);
    end
    retryPulse = 1'b0;
    @(negedge clk);
    check(!retriesExhausted, "R10 idle retries ignored", retriesExhausted, 0);

    summaryDone = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule